// File: doc/BRIEF.md
# Low-Side Switch Fault Latch and Release Sequencer

This block is the digital control core of a low-side power switch. It turns a sampled on/off command into a gate-enable. A thermal shutdown latches that gate-enable off. The block reports the latched fault by pulling a shared status line low through an open-drain driver. The analog front end supplies the over-temperature flag and two supply-monitor flags as digital levels. The block sees the status line only as the logic level that an input buffer reads back.

Once the latch is set, it clears in only two ways. The first is an ordered release sequence on the status line: the line stays low for a minimum number of cycles, then high for a minimum number of cycles. The second is a deep supply drop. A shallow supply drop only turns the output off. The release sequence works the same way when the status line and the command input are wired together. A fast PWM command on that combined net therefore cannot clear a latched fault.

Top module: `lss_fault_ctrl`

## Requirements
- R1: With no fault latched and both supply flags low, `gate_en` follows `cmd_in`. The command passes through a two-flop synchroniser, so `gate_en` changes on the third rising edge after `cmd_in` changes.
- R2: When `ot_flag` is high at a rising edge while `gate_en` is high, the fault latch sets and `gate_en` goes low at that same edge. It stays low whatever `cmd_in` does until the latch clears.
- R3: `stat_pd` rises exactly `PD_DELAY` rising edges after the edge that set the latch. It stays high while the latch holds and goes low at the edge where the latch clears.
- R4: `ot_flag` has no effect while `gate_en` is low. No latch is set, and the command is followed normally afterwards.
- R5: The latch clears only after two runs of synchronised status samples: at least `LOW_DWELL` consecutive low samples, then `HIGH_DWELL` consecutive high samples. The latch clears, and `gate_en` may rise, on the edge that takes the last high sample. That edge is the (`HIGH_DWELL`+2)-th rising edge after the line goes high. No earlier edge clears the latch.
- R6: A low run of `LOW_DWELL`-1 samples followed by any length of high does not clear the latch.
- R7: A low sample during the high phase abandons the sequence, and low counting starts again from that sample. A following low run shorter than `LOW_DWELL` then cannot clear the latch.
- R8: While `uv_off` is high, `gate_en` is low from the next edge on. A latched fault and `stat_pd` are kept.
- R9: `uv_reset` high clears the fault latch and `stat_pd` at the next edge and also holds `gate_en` low.
- R10: When the status line and `cmd_in` are the same net, a PWM command whose low pulses are shorter than `LOW_DWELL` never clears the latch. A low pulse of at least `LOW_DWELL` followed by `HIGH_DWELL` high does clear it.
- R11: After reset, `gate_en` and `stat_pd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_in | input | 1 | Asynchronous on/off command |
| ot_flag | input | 1 | Digitised over-temperature flag, synchronous to clk |
| uv_off | input | 1 | Supply below the switch-off threshold, synchronous to clk |
| uv_reset | input | 1 | Supply below the deeper reset threshold, synchronous to clk |
| stat_line | input | 1 | Level read back from the open-drain status line, asynchronous |
| gate_en | output | 1 | Enable for the power stage gate driver |
| stat_pd | output | 1 | Active-high enable of the status-line pull-down |

## Verification
The bench builds the block with `PD_DELAY`=5, `LOW_DWELL`=40 and `HIGH_DWELL`=8. At these values every dwell boundary is a few dozen cycles away. The bench can therefore drive low runs of exactly `LOW_DWELL`-1 and `LOW_DWELL` samples, an interrupted high phase, and several periods of PWM on the combined command/status net. At each of these it checks the exact edge on which the output comes back. The status line is modelled as a pull-up overridden by the block's pull-down or by a push-pull driver in the bench. This makes the fault's own pull-down feed the low phase, as it does on a real board.

// File: rtl/lss_pkg.sv
// Shared types and helpers for the low-side switch fault controller.
// Assumes: nothing beyond IEEE 1800-2017.
package lss_pkg;

    // Phases of the release sequencer.
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_LOW    = 2'd1,
        SEQ_LOW_OK = 2'd2,
        SEQ_HIGH   = 2'd3
    } seq_state_t;

    // Bits needed to hold values 0..n.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/lss_sync2.sv
// Two-flop synchroniser, one chain per bit.
// Assumes: inputs are asynchronous levels; RST_VAL gives each bit's idle level.
module lss_sync2 #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q;
        logic stab_q;

        // Capture then re-register each bit to settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[b];
                stab_q <= RST_VAL[b];
            end else begin
                meta_q <= d_async[b];
                stab_q <= meta_q;
            end
        end

        assign q_sync[b] = stab_q;
    end

endmodule

// File: rtl/lss_pd_timer.sv
// Delays the status pull-down after a fault latch sets.
// Assumes: hold is the next-state value of the fault latch, so the pull-down
// drops at the same edge on which the latch clears.
module lss_pd_timer #(
    parameter int PD_DELAY = 45
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic pd
);
    import lss_pkg::*;

    localparam int CW = cnt_width(PD_DELAY);

    logic [CW-1:0] cnt_q;

    // Count edges since the latch set; raise pd once PD_DELAY is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pd    <= 1'b0;
        end else if (!hold) begin
            cnt_q <= '0;
            pd    <= 1'b0;
        end else if (!pd) begin
            if (cnt_q == CW'(PD_DELAY)) pd <= 1'b1;
            else                        cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: once raised, the pull-down stays while the latch holds.
    a_r3_pd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pd && hold) |=> pd);

    // R3: the delay counter never runs past its limit.
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(PD_DELAY));

endmodule

// File: rtl/lss_rst_seq.sv
// Release sequencer: watches the synchronised status level while armed and
// pulses release_o after LOW_DWELL low samples followed by HIGH_DWELL high ones.
// Assumes: armed is the fault latch; LOW_DWELL >= 1, HIGH_DWELL >= 1.
module lss_rst_seq #(
    parameter int LOW_DWELL  = 24000,
    parameter int HIGH_DWELL = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic line_s,
    output logic release_o
);
    import lss_pkg::*;

    localparam int LW = cnt_width(LOW_DWELL);
    localparam int HW = cnt_width(HIGH_DWELL);

    seq_state_t    st_q;
    logic [LW-1:0] lo_cnt_q;
    logic [HW-1:0] hi_cnt_q;

    // Release on the sample that completes the high dwell.
    always_comb begin
        release_o = 1'b0;
        if (armed && line_s) begin
            if (st_q == SEQ_LOW_OK && HIGH_DWELL == 1)                  release_o = 1'b1;
            if (st_q == SEQ_HIGH && hi_cnt_q == HW'(HIGH_DWELL - 1))  release_o = 1'b1;
        end
    end

    // Walk the low-then-high phases; counters stop at their limits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= SEQ_IDLE;
            lo_cnt_q <= '0;
            hi_cnt_q <= '0;
        end else if (!armed || release_o) begin
            st_q     <= SEQ_IDLE;
            lo_cnt_q <= '0;
            hi_cnt_q <= '0;
        end else begin
            case (st_q)
                SEQ_IDLE: begin
                    st_q     <= SEQ_LOW;
                    lo_cnt_q <= '0;
                end
                SEQ_LOW: begin
                    if (!line_s) begin
                        if (lo_cnt_q == LW'(LOW_DWELL - 1)) st_q <= SEQ_LOW_OK;
                        else                                lo_cnt_q <= lo_cnt_q + 1'b1;
                    end else begin
                        lo_cnt_q <= '0;
                    end
                end
                SEQ_LOW_OK: begin
                    if (line_s) begin
                        st_q     <= SEQ_HIGH;
                        hi_cnt_q <= HW'(1);
                        lo_cnt_q <= '0;
                    end
                end
                default: begin
                    if (!line_s) begin
                        hi_cnt_q <= '0;
                        if (LOW_DWELL == 1) begin
                            st_q <= SEQ_LOW_OK;
                        end else begin
                            st_q     <= SEQ_LOW;
                            lo_cnt_q <= LW'(1);
                        end
                    end else begin
                        hi_cnt_q <= hi_cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // R5: the low counter saturates below its limit.
    a_r5_low_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cnt_q <= LW'(LOW_DWELL - 1));

    // R5: the high counter never passes the high dwell.
    a_r5_high_bound: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt_q <= HW'(HIGH_DWELL));

    // R6: the high phase is only entered from a completed low dwell.
    a_r6_high_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_HIGH && $past(st_q) != SEQ_HIGH) |-> $past(st_q) == SEQ_LOW_OK);

    // R7: a low sample in the high phase sends the sequence back to low counting.
    a_r7_low_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && st_q == SEQ_HIGH && !line_s) |=> st_q != SEQ_HIGH);

endmodule

// File: rtl/lss_fault_ctrl.sv
// Fault controller of a low-side switch: gates the command, latches thermal
// shutdown, drives the status pull-down and releases via sequence or deep UV.
// Assumes: ot_flag, uv_off, uv_reset are synchronous to clk; cmd_in and
// stat_line are asynchronous.
module lss_fault_ctrl #(
    parameter int PD_DELAY   = 45,
    parameter int LOW_DWELL  = 24000,
    parameter int HIGH_DWELL = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_in,
    input  logic ot_flag,
    input  logic uv_off,
    input  logic uv_reset,
    input  logic stat_line,
    output logic gate_en,
    output logic stat_pd
);

    logic [1:0] sync_q;
    logic       cmd_s;
    logic       line_s;
    logic       latch_q;
    logic       latch_set;
    logic       latch_nxt;
    logic       seq_release;
    logic       gate_d;

    // Bit 1 is the status line (idles high), bit 0 the command (idles low).
    lss_sync2 #(
        .WIDTH   (2),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({stat_line, cmd_in}),
        .q_sync  (sync_q)
    );

    assign cmd_s  = sync_q[0];
    assign line_s = sync_q[1];

    lss_rst_seq #(
        .LOW_DWELL  (LOW_DWELL),
        .HIGH_DWELL (HIGH_DWELL)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (latch_q),
        .line_s    (line_s),
        .release_o (seq_release)
    );

    // Thermal flag counts only while the output is on; deep UV and release win.
    always_comb begin
        latch_set = ot_flag & gate_en;
        latch_nxt = (latch_q | latch_set) & ~uv_reset & ~seq_release;
        gate_d    = cmd_s & ~latch_nxt & ~uv_off & ~uv_reset;
    end

    // Hold the fault latch and the registered gate enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
            gate_en <= 1'b0;
        end else begin
            latch_q <= latch_nxt;
            gate_en <= gate_d;
        end
    end

    lss_pd_timer #(
        .PD_DELAY (PD_DELAY)
    ) u_pd (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (latch_nxt),
        .pd    (stat_pd)
    );

    // R2: a latched fault keeps the gate off.
    a_r2_off_when_latched: assert property (@(posedge clk) disable iff (!rst_n)
        latch_q |-> !gate_en);

    // R3: the pull-down is only active with a fault latched.
    a_r3_pd_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        stat_pd |-> latch_q);

    // R4: with the output off, the thermal flag cannot set the latch.
    a_r4_ot_ignored_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en && !latch_q) |=> !latch_q);

    // R8: shallow undervoltage turns the gate off on the next edge.
    a_r8_uv_off_gate: assert property (@(posedge clk) disable iff (!rst_n)
        uv_off |=> !gate_en);

    // R8: shallow undervoltage keeps an existing latch.
    a_r8_uv_off_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && uv_off && !uv_reset && !seq_release) |=> latch_q);

    // R9: deep undervoltage clears latch and pull-down.
    a_r9_uv_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        uv_reset |=> (!latch_q && !stat_pd && !gate_en));

endmodule

// File: tb/lss_fault_ctrl_bench.sv
// Directed bench for lss_fault_ctrl: one task per scenario.
module lss_fault_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int P = 5;
    localparam int L = 40;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic cmd_in;
    logic ot_flag;
    logic uv_off;
    logic uv_reset;
    logic drv_en;
    logic drv_val;
    logic tied;
    logic stat_line;
    logic gate_en;
    logic stat_pd;

    int n_vec = 0;
    int n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Status net: pull-up, open-drain pull-down, optional push-pull driver,
    // or the command net itself when tied.
    assign stat_line = tied ? cmd_in : (drv_en ? drv_val : ~stat_pd);

    lss_fault_ctrl #(
        .PD_DELAY   (P),
        .LOW_DWELL  (L),
        .HIGH_DWELL (H)
    ) u_lss_fault_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_in    (cmd_in),
        .ot_flag   (ot_flag),
        .uv_off    (uv_off),
        .uv_reset  (uv_reset),
        .stat_line (stat_line),
        .gate_en   (gate_en),
        .stat_pd   (stat_pd)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Turn the output on, raise the thermal flag and check the latch and pull-down timing.
    task automatic latch_it();
        cmd_in = 1'b1;
        step(4);
        chk("R1", "gate on before fault", gate_en, 1'b1);
        ot_flag = 1'b1;
        step(1);
        chk("R2", "gate off at latch edge", gate_en, 1'b0);
        ot_flag = 1'b0;
        step(P - 1);
        chk("R3", "pull-down before delay", stat_pd, 1'b0);
        step(1);
        chk("R3", "pull-down after delay", stat_pd, 1'b1);
    endtask

    task automatic t_reset();
        chk("R11", "gate after reset", gate_en, 1'b0);
        chk("R11", "pull-down after reset", stat_pd, 1'b0);
    endtask

    task automatic t_follow();
        cmd_in = 1'b1;
        step(2);
        chk("R1", "gate before 3rd edge", gate_en, 1'b0);
        step(1);
        chk("R1", "gate at 3rd edge", gate_en, 1'b1);
        cmd_in = 1'b0;
        step(2);
        chk("R1", "gate before 3rd edge off", gate_en, 1'b1);
        step(1);
        chk("R1", "gate off at 3rd edge", gate_en, 1'b0);
    endtask

    task automatic t_latch_and_release();
        latch_it();
        cmd_in = 1'b0;
        step(5);
        cmd_in = 1'b1;
        step(5);
        chk("R2", "command ignored while latched", gate_en, 1'b0);
        step(L + 5);
        drv_en  = 1'b1;
        drv_val = 1'b1;
        step(H + 1);
        chk("R5", "no release before high dwell", gate_en, 1'b0);
        chk("R3", "pull-down held before release", stat_pd, 1'b1);
        step(1);
        chk("R5", "gate back after high dwell", gate_en, 1'b1);
        chk("R3", "pull-down released with latch", stat_pd, 1'b0);
        drv_en = 1'b0;
    endtask

    task automatic t_low_boundary();
        latch_it();
        drv_en  = 1'b1;
        drv_val = 1'b1;
        step(L + 10);
        drv_val = 1'b0;
        step(L - 1);
        drv_val = 1'b1;
        step(H + 10);
        chk("R6", "short low keeps latch", gate_en, 1'b0);
        chk("R6", "short low keeps pull-down", stat_pd, 1'b1);
        drv_val = 1'b0;
        step(L);
        drv_val = 1'b1;
        step(H + 1);
        chk("R5", "exact low dwell, before high done", gate_en, 1'b0);
        step(1);
        chk("R5", "exact low dwell releases", gate_en, 1'b1);
        drv_en = 1'b0;
    endtask

    task automatic t_high_interrupt();
        latch_it();
        drv_en  = 1'b1;
        drv_val = 1'b0;
        step(L + 2);
        drv_val = 1'b1;
        step(H - 1);
        drv_val = 1'b0;
        step(L / 2);
        drv_val = 1'b1;
        step(H + 10);
        chk("R7", "interrupted high phase keeps latch", gate_en, 1'b0);
        chk("R7", "interrupted high phase keeps pull-down", stat_pd, 1'b1);
        drv_val = 1'b0;
        step(L + 2);
        drv_val = 1'b1;
        step(H + 2);
        chk("R7", "full sequence after restart releases", gate_en, 1'b1);
        drv_en = 1'b0;
    endtask

    task automatic t_undervoltage();
        cmd_in = 1'b1;
        step(4);
        uv_off = 1'b1;
        step(1);
        chk("R8", "shallow UV gate off", gate_en, 1'b0);
        uv_off = 1'b0;
        step(1);
        chk("R8", "gate back after shallow UV", gate_en, 1'b1);
        latch_it();
        uv_off = 1'b1;
        step(3);
        uv_off = 1'b0;
        step(3);
        chk("R8", "shallow UV keeps latch", gate_en, 1'b0);
        chk("R8", "shallow UV keeps pull-down", stat_pd, 1'b1);
        uv_reset = 1'b1;
        step(1);
        chk("R9", "deep UV clears pull-down", stat_pd, 1'b0);
        chk("R9", "deep UV holds gate off", gate_en, 1'b0);
        uv_reset = 1'b0;
        step(1);
        chk("R9", "gate follows after deep UV", gate_en, 1'b1);
    endtask

    task automatic t_ot_idle();
        cmd_in = 1'b0;
        step(4);
        ot_flag = 1'b1;
        step(3);
        ot_flag = 1'b0;
        cmd_in  = 1'b1;
        step(3);
        chk("R4", "thermal flag ignored while off", gate_en, 1'b1);
        chk("R4", "no pull-down after ignored flag", stat_pd, 1'b0);
    endtask

    task automatic t_tied_pwm();
        tied = 1'b1;
        latch_it();
        for (int k = 0; k < 6; k++) begin
            cmd_in = 1'b0;
            step(L - 10);
            cmd_in = 1'b1;
            step(H + 4);
            chk("R10", "PWM on tied net keeps latch", gate_en, 1'b0);
        end
        cmd_in = 1'b0;
        step(L + 2);
        cmd_in = 1'b1;
        step(H + 1);
        chk("R10", "tied net before high dwell", gate_en, 1'b0);
        step(1);
        chk("R10", "tied net long low then high releases", gate_en, 1'b1);
        tied = 1'b0;
    endtask

    initial begin
        rst_n    = 1'b0;
        cmd_in   = 1'b0;
        ot_flag  = 1'b0;
        uv_off   = 1'b0;
        uv_reset = 1'b0;
        drv_en   = 1'b0;
        drv_val  = 1'b1;
        tied     = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_follow();
        t_latch_and_release();
        t_low_boundary();
        t_high_interrupt();
        t_undervoltage();
        t_ot_idle();
        t_tied_pwm();
        step(2);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_vec++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule